// File: doc/BRIEF.md
# Serial Instruction Next-Address Sequencer

This block takes one 22-bit single-address instruction word and resolves it into two results: the effective operand address, given as a line and a sector, and the place the following instruction is to come from. The next location is either the sector numbered one above the current instruction, or the word that next passes the read point in the current line once the operand has gone by. An index tag makes a stored index address stand in for the instruction's own line and sector. The address is replaced, not added to. A small range lookup on the opcode marks some opcodes as immediate-operand (the line and sector fields are raw data) and others as next-address (the sector field names the next instruction). All other opcodes are address-mode.

The block runs as a three-state machine. `ST_IDLE` waits for `instr_valid` and captures the word, the index value and the current sector (transition IDLE->DECODE). `ST_DECODE` splits the fields and registers the operand address and opcode (transition DECODE->RESOLVE). `ST_RESOLVE` registers the next sector and the wait flag and raises `res_valid` (transition RESOLVE->IDLE). A request seen outside `ST_IDLE` is dropped. Ordinary sequencing never changes line. Sector arithmetic wraps modulo 256.

Top module: `nxa_seq`

## Requirements
- R1: Field layout, from bit 0: sector [7:0], sequence tag [8], opcode [14:9], line [20:15], index tag [21]. The index value input carries line in [13:8] and sector in [7:0].
- R2: While `rst_n` is low, and after it, `res_valid`, `opnd_line`, `opnd_sector`, `next_sector`, `wait_next` and `opcode` are all zero and the machine is in `ST_IDLE`.
- R3: `instr_valid` high at a rising edge in `ST_IDLE` gives `res_valid` high for exactly the one cycle that follows the second rising edge after it.
- R4: `instr_valid` seen while in `ST_DECODE` or `ST_RESOLVE` is ignored. It neither changes the pending result nor produces a second one.
- R5: For an address-mode opcode with the index tag clear, the operand line and sector equal the instruction's line and sector fields.
- R6: For an address-mode or next-address opcode with the index tag set, the operand line and sector equal the index value's line and sector. There is no addition.
- R7: For an address-mode or immediate opcode with the sequence tag clear, `next_sector` is `cur_sector`+1 modulo 256 and `wait_next` is 0.
- R8: With the sequence tag set, `wait_next` is 1. `next_sector` is the operand sector+1 for address-mode opcodes, and `cur_sector`+1 for immediate opcodes (both modulo 256).
- R9: Immediate opcodes are 0x10 to 0x17. For them the operand outputs carry the raw line and sector fields, and the index tag has no effect.
- R10: Next-address opcodes are 0x30 to 0x33. For them `next_sector` equals the operand sector, `wait_next` is 0, and the sequence tag has no effect.
- R11: `opcode` equals bits [14:9] of the instruction when `res_valid` is high.
- R12: A sector increment from 0xFF yields 0x00, and the operand line is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word present, accepted in ST_IDLE |
| instr_word | input | 22 | Instruction word |
| index_addr | input | 14 | Index register value {line, sector} |
| cur_sector | input | 8 | Sector of the current instruction |
| res_valid | output | 1 | One-cycle pulse: results valid |
| opnd_line | output | 6 | Effective operand line |
| opnd_sector | output | 8 | Effective operand sector |
| next_sector | output | 8 | Sector of the next instruction |
| wait_next | output | 1 | Take the next word passing the read point |
| opcode | output | 6 | Opcode field |

## Verification
The operand line, operand sector and opcode are registered at the first edge after acceptance. The next sector, the wait flag and `res_valid` follow one edge later, so every result is due at the second rising edge after the accepting edge. The bench drives inputs on falling edges. It confirms `res_valid` is still low half a cycle after the first edge, then samples every output at the falling edge after the second edge, when `res_valid` must be high. The busy-drop test holds `instr_valid` high through both busy edges and then checks for one result carrying the first instruction and no further pulse.

// File: rtl/nxa_seq_pkg.sv
package nxa_seq_pkg;

    localparam int SEC_W  = 8;
    localparam int LINE_W = 6;
    localparam int OP_W   = 6;
    localparam int WORD_W = 1 + LINE_W + OP_W + 1 + SEC_W;
    localparam int IDX_W  = LINE_W + SEC_W;

    typedef struct packed {
        logic              idx_tag;
        logic [LINE_W-1:0] line;
        logic [OP_W-1:0]   op;
        logic              seq_tag;
        logic [SEC_W-1:0]  sector;
    } instr_t;

    typedef enum logic [1:0] {
        CLS_ADDR,
        CLS_IMM,
        CLS_NEXT
    } op_class_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DECODE,
        ST_RESOLVE
    } seq_state_e;

    function automatic op_class_e classify(
        input logic [OP_W-1:0] op,
        input logic [OP_W-1:0] imm_lo,
        input logic [OP_W-1:0] imm_hi,
        input logic [OP_W-1:0] nxt_lo,
        input logic [OP_W-1:0] nxt_hi
    );
        if (op >= imm_lo && op <= imm_hi)      return CLS_IMM;
        else if (op >= nxt_lo && op <= nxt_hi) return CLS_NEXT;
        else                                   return CLS_ADDR;
    endfunction

endpackage

// File: rtl/nxa_field_split.sv
module nxa_field_split
    import nxa_seq_pkg::*;
#(
    parameter logic [OP_W-1:0] IMM_LO = 6'h10,
    parameter logic [OP_W-1:0] IMM_HI = 6'h17,
    parameter logic [OP_W-1:0] NXT_LO = 6'h30,
    parameter logic [OP_W-1:0] NXT_HI = 6'h33
) (
    input  logic [WORD_W-1:0] word,
    output instr_t            fld,
    output op_class_e         cls
);
    // R1: fixed field placement comes from the packed struct order
    assign fld = instr_t'(word);
    assign cls = classify(fld.op, IMM_LO, IMM_HI, NXT_LO, NXT_HI);
endmodule

// File: rtl/nxa_addr_sel.sv
module nxa_addr_sel
    import nxa_seq_pkg::*;
(
    input  op_class_e         cls,
    input  instr_t            fld,
    input  logic [IDX_W-1:0]  idx_val,
    output logic [LINE_W-1:0] eff_line,
    output logic [SEC_W-1:0]  eff_sec
);
    always_comb begin
        eff_line = fld.line;
        eff_sec  = fld.sector;
        unique case (cls)
            CLS_IMM: begin
                // immediate data: fields pass untouched, index tag ignored
                eff_line = fld.line;
                eff_sec  = fld.sector;
            end
            CLS_ADDR, CLS_NEXT: begin
                if (fld.idx_tag) begin
                    // substitution, no sum
                    eff_line = idx_val[IDX_W-1:SEC_W];
                    eff_sec  = idx_val[SEC_W-1:0];
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/nxa_next_gen.sv
module nxa_next_gen
    import nxa_seq_pkg::*;
(
    input  op_class_e        cls,
    input  logic             seq_tag,
    input  logic [SEC_W-1:0] opnd_sec,
    input  logic [SEC_W-1:0] cur_sec,
    output logic [SEC_W-1:0] next_sec,
    output logic             wait_flag
);
    logic [SEC_W-1:0] cur_inc;
    logic [SEC_W-1:0] opnd_inc;

    // carry out dropped: wraps inside the line
    assign cur_inc  = cur_sec + SEC_W'(1);
    assign opnd_inc = opnd_sec + SEC_W'(1);

    always_comb begin
        next_sec  = cur_inc;
        wait_flag = 1'b0;
        unique case (cls)
            CLS_ADDR: begin
                next_sec  = seq_tag ? opnd_inc : cur_inc;
                wait_flag = seq_tag;
            end
            CLS_IMM: begin
                next_sec  = cur_inc;
                wait_flag = seq_tag;
            end
            CLS_NEXT: begin
                next_sec  = opnd_sec;
                wait_flag = 1'b0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/nxa_seq.sv
module nxa_seq
    import nxa_seq_pkg::*;
#(
    parameter logic [OP_W-1:0] IMM_LO = 6'h10,
    parameter logic [OP_W-1:0] IMM_HI = 6'h17,
    parameter logic [OP_W-1:0] NXT_LO = 6'h30,
    parameter logic [OP_W-1:0] NXT_HI = 6'h33
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [WORD_W-1:0] instr_word,
    input  logic [IDX_W-1:0]  index_addr,
    input  logic [SEC_W-1:0]  cur_sector,
    output logic              res_valid,
    output logic [LINE_W-1:0] opnd_line,
    output logic [SEC_W-1:0]  opnd_sector,
    output logic [SEC_W-1:0]  next_sector,
    output logic              wait_next,
    output logic [OP_W-1:0]   opcode
);
    seq_state_e state_q, state_d;
    logic       busy;
    logic       accept;

    logic [WORD_W-1:0] cap_word;
    logic [IDX_W-1:0]  cap_idx;
    logic [SEC_W-1:0]  cap_cur;
    op_class_e         cls_q;
    logic              seq_q;

    instr_t            fld;
    op_class_e         cls;
    logic [LINE_W-1:0] sel_line;
    logic [SEC_W-1:0]  sel_sec;
    logic [SEC_W-1:0]  ng_next;
    logic              ng_wait;

    assign busy   = (state_q != ST_IDLE);
    assign accept = instr_valid && !busy;

    nxa_field_split #(
        .IMM_LO(IMM_LO), .IMM_HI(IMM_HI),
        .NXT_LO(NXT_LO), .NXT_HI(NXT_HI)
    ) u_split (
        .word (cap_word),
        .fld  (fld),
        .cls  (cls)
    );

    nxa_addr_sel u_addr (
        .cls      (cls),
        .fld      (fld),
        .idx_val  (cap_idx),
        .eff_line (sel_line),
        .eff_sec  (sel_sec)
    );

    nxa_next_gen u_next (
        .cls       (cls_q),
        .seq_tag   (seq_q),
        .opnd_sec  (opnd_sector),
        .cur_sec   (cap_cur),
        .next_sec  (ng_next),
        .wait_flag (ng_wait)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (accept) state_d = ST_DECODE;
            ST_DECODE:  state_d = ST_RESOLVE;
            ST_RESOLVE: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // per-state register updates and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_word    <= '0;
            cap_idx     <= '0;
            cap_cur     <= '0;
            cls_q       <= CLS_ADDR;
            seq_q       <= 1'b0;
            res_valid   <= 1'b0;
            opnd_line   <= '0;
            opnd_sector <= '0;
            next_sector <= '0;
            wait_next   <= 1'b0;
            opcode      <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    res_valid <= 1'b0;
                    if (accept) begin
                        cap_word <= instr_word;
                        cap_idx  <= index_addr;
                        cap_cur  <= cur_sector;
                    end
                end
                ST_DECODE: begin
                    opnd_line   <= sel_line;
                    opnd_sector <= sel_sec;
                    opcode      <= fld.op;
                    cls_q       <= cls;
                    seq_q       <= fld.seq_tag;
                end
                ST_RESOLVE: begin
                    next_sector <= ng_next;
                    wait_next   <= ng_wait;
                    res_valid   <= 1'b1;
                end
                default: res_valid <= 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/nxa_seq_chk.sv
module nxa_seq_chk
    import nxa_seq_pkg::*;
#(
    parameter logic [OP_W-1:0] IMM_LO = 6'h10,
    parameter logic [OP_W-1:0] IMM_HI = 6'h17,
    parameter logic [OP_W-1:0] NXT_LO = 6'h30,
    parameter logic [OP_W-1:0] NXT_HI = 6'h33
) (
    input logic              clk,
    input logic              rst_n,
    input logic              instr_valid,
    input logic              busy,
    input logic              res_valid,
    input logic              cap_idx_tag,
    input logic              cap_seq_tag,
    input logic [IDX_W-1:0]  cap_idx,
    input logic [SEC_W-1:0]  cap_cur,
    input logic [WORD_W-1:0] cap_word,
    input logic [LINE_W-1:0] opnd_line,
    input logic [SEC_W-1:0]  opnd_sector,
    input logic [SEC_W-1:0]  next_sector,
    input logic              wait_next
);
    op_class_e ck_cls;
    assign ck_cls = classify(cap_word[14:9], IMM_LO, IMM_HI, NXT_LO, NXT_HI);

    assert_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    assert_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !busy) |=> busy);

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cap_word));

    assert_index_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && ck_cls != CLS_IMM && cap_idx_tag)
            |-> (opnd_sector == cap_idx[SEC_W-1:0] &&
                 opnd_line == cap_idx[IDX_W-1:SEC_W]));

    assert_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && ck_cls != CLS_NEXT && !cap_seq_tag)
            |-> (next_sector == SEC_W'(cap_cur + SEC_W'(1)) && !wait_next));

    assert_jump_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && ck_cls == CLS_NEXT)
            |-> (!wait_next && next_sector == opnd_sector));
endmodule

bind nxa_seq nxa_seq_chk #(
    .IMM_LO(IMM_LO), .IMM_HI(IMM_HI), .NXT_LO(NXT_LO), .NXT_HI(NXT_HI)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .busy        (busy),
    .res_valid   (res_valid),
    .cap_idx_tag (cap_word[21]),
    .cap_seq_tag (cap_word[8]),
    .cap_idx     (cap_idx),
    .cap_cur     (cap_cur),
    .cap_word    (cap_word),
    .opnd_line   (opnd_line),
    .opnd_sector (opnd_sector),
    .next_sector (next_sector),
    .wait_next   (wait_next)
);

// File: tb/nxa_seq_tb.sv
module nxa_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [21:0] instr_word = '0;
    logic [13:0] index_addr = '0;
    logic [7:0]  cur_sector = '0;
    logic        res_valid;
    logic [5:0]  opnd_line;
    logic [7:0]  opnd_sector;
    logic [7:0]  next_sector;
    logic        wait_next;
    logic [5:0]  opcode;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    nxa_seq u_dut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid),
        .instr_word(instr_word), .index_addr(index_addr),
        .cur_sector(cur_sector), .res_valid(res_valid),
        .opnd_line(opnd_line), .opnd_sector(opnd_sector),
        .next_sector(next_sector), .wait_next(wait_next), .opcode(opcode)
    );

    // R1 layout: {idx[21], line[20:15], op[14:9], seq[8], sector[7:0]}
    function automatic logic [21:0] mkw(input logic ix, input logic [5:0] ln,
                                        input logic [5:0] op, input logic sq,
                                        input logic [7:0] sc);
        return {ix, ln, op, sq, sc};
    endfunction

    typedef struct packed {
        logic [21:0] word;
        logic [13:0] idx;
        logic [7:0]  cur;
        logic [5:0]  e_line;
        logic [7:0]  e_sec;
        logic [7:0]  e_next;
        logic        e_wait;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{mkw(0, 6'd5,  6'h01, 0, 8'h20), 14'h3FFF,          8'h40, 6'd5,  8'h20, 8'h41, 1'b0}, // R5 R7
        '{mkw(1, 6'd5,  6'h01, 0, 8'h20), {6'd9,  8'h77},    8'h10, 6'd9,  8'h77, 8'h11, 1'b0}, // R6 R7
        '{mkw(0, 6'd3,  6'h02, 1, 8'h50), 14'h0000,          8'h10, 6'd3,  8'h50, 8'h51, 1'b1}, // R8
        '{mkw(1, 6'd3,  6'h02, 1, 8'h50), {6'd2,  8'h80},    8'h10, 6'd2,  8'h80, 8'h81, 1'b1}, // R6 R8
        '{mkw(0, 6'd7,  6'h01, 0, 8'h00), 14'h0000,          8'hFF, 6'd7,  8'h00, 8'h00, 1'b0}, // R12
        '{mkw(0, 6'd7,  6'h01, 1, 8'hFF), 14'h0000,          8'h03, 6'd7,  8'hFF, 8'h00, 1'b1}, // R12 R8
        '{mkw(1, 6'd12, 6'h10, 0, 8'h05), {6'd1,  8'h01},    8'h22, 6'd12, 8'h05, 8'h23, 1'b0}, // R9
        '{mkw(0, 6'd63, 6'h17, 1, 8'hAA), 14'h0000,          8'hFF, 6'd63, 8'hAA, 8'h00, 1'b1}, // R9 R8
        '{mkw(0, 6'd4,  6'h30, 1, 8'h9C), 14'h0000,          8'h05, 6'd4,  8'h9C, 8'h9C, 1'b0}, // R10
        '{mkw(1, 6'd4,  6'h33, 0, 8'h9C), {6'd11, 8'h44},    8'h05, 6'd11, 8'h44, 8'h44, 1'b0}, // R10 R6
        '{mkw(0, 6'd1,  6'h0F, 1, 8'h10), 14'h0000,          8'h00, 6'd1,  8'h10, 8'h11, 1'b1}, // R5 R8
        '{mkw(1, 6'd1,  6'h18, 0, 8'h10), 14'h0000,          8'h07, 6'd0,  8'h00, 8'h08, 1'b0}, // R6 R7
        '{mkw(0, 6'd2,  6'h34, 0, 8'h33), 14'h0000,          8'h33, 6'd2,  8'h33, 8'h34, 1'b0}  // R5 R7
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_all(input vec_t v);
        chk("R3 res_valid", 32'(res_valid), 32'd1);
        chk("R5/R6/R9 opnd_line", 32'(opnd_line), 32'(v.e_line));
        chk("R5/R6/R9 opnd_sector", 32'(opnd_sector), 32'(v.e_sec));
        chk("R7/R8/R10/R12 next_sector", 32'(next_sector), 32'(v.e_next));
        chk("R8/R10 wait_next", 32'(wait_next), 32'(v.e_wait));
        chk("R11 opcode", 32'(opcode), 32'(v.word[14:9]));
    endtask

    task automatic apply(input vec_t v);
        @(negedge clk);
        instr_word  = v.word;
        index_addr  = v.idx;
        cur_sector  = v.cur;
        instr_valid = 1'b1;
        @(negedge clk);           // accepting edge passed
        instr_valid = 1'b0;
        @(negedge clk);           // one edge later
        chk("R3 early res_valid", 32'(res_valid), 32'd0);
        @(negedge clk);           // second edge later
        check_all(v);
    endtask

    task automatic check_zero(input string tag);
        chk({tag, " res_valid"}, 32'(res_valid), 32'd0);
        chk({tag, " opnd_line"}, 32'(opnd_line), 32'd0);
        chk({tag, " opnd_sector"}, 32'(opnd_sector), 32'd0);
        chk({tag, " next_sector"}, 32'(next_sector), 32'd0);
        chk({tag, " wait_next"}, 32'(wait_next), 32'd0);
        chk({tag, " opcode"}, 32'(opcode), 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog R3 actual=timeout expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R2: reset state
        repeat (3) @(negedge clk);
        check_zero("R2 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_zero("R2 after reset");

        // table walk
        for (int i = 0; i < NV; i++) apply(VEC[i]);

        // R3: pulse lasts one cycle
        @(negedge clk);
        chk("R3 pulse end", 32'(res_valid), 32'd0);

        // R4: request while busy is dropped
        @(negedge clk);
        instr_word  = mkw(0, 6'd8, 6'h05, 0, 8'h60);
        index_addr  = 14'h0000;
        cur_sector  = 8'h60;
        instr_valid = 1'b1;
        @(negedge clk);
        instr_word  = mkw(1, 6'd9, 6'h31, 1, 8'hEE);
        index_addr  = {6'd30, 8'h3C};
        cur_sector  = 8'h01;
        @(negedge clk);
        chk("R4 early res_valid", 32'(res_valid), 32'd0);
        @(negedge clk);
        instr_valid = 1'b0;
        check_all('{mkw(0, 6'd8, 6'h05, 0, 8'h60), 14'h0000, 8'h60,
                    6'd8, 8'h60, 8'h61, 1'b0});
        @(negedge clk);
        chk("R4 no second result", 32'(res_valid), 32'd0);
        @(negedge clk);
        chk("R4 still no result", 32'(res_valid), 32'd0);
        @(negedge clk);
        chk("R4 stays idle", 32'(res_valid), 32'd0);

        // R2: reset mid-run clears the outputs
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_zero("R2 mid-run reset");
        rst_n = 1'b1;

        // R12: line kept across wrap after reset
        apply('{mkw(0, 6'd62, 6'h00, 0, 8'h01), 14'h0000, 8'hFF,
                6'd62, 8'h01, 8'h00, 1'b0});

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule